// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block turns a fast module clock into the serial clock of an SPI master. A 13-bit rate word picks one of two divide laws. The exponential law divides by a power of two. The linear law divides by an even number that rises in steps of two. The serial clock has a 50% duty cycle and rests at the level that the clock-polarity input gives.

Next to the serial clock, the block gives two strobes, each one module-clock cycle wide. One marks every leading (first) edge and one marks every trailing (second) edge, so the shift engine can launch and sample data without looking at the serial clock itself. The clock runs only while the transfer-active input is high. The rate word is captured only while that input is low, so a transfer always runs at a single rate. Choosing the rate word for a wanted frequency is done in software.

Top module: `spi_dual_div`

## Requirements
- R1: After reset, `sclk` equals `cpol`, and `lead_pulse` and `trail_pulse` are both low.
- R2: With `rate_cfg[12]`=0 and exponent `e`=`rate_cfg[11:8]` in the range 1 to 15, each half period of `sclk` lasts 2^(e-1) module-clock cycles, so the divide ratio is 2^e.
- R3: With `rate_cfg[12]`=0 and `e`=0, the block divides by two, the same as `e`=1.
- R4: With `rate_cfg[12]`=1 and `f`=`rate_cfg[7:0]`, each half period lasts `f`+1 cycles, so the ratio is 2·(`f`+1). This covers the smallest ratio of 2 (`f`=0) and the largest ratio of 512 (`f`=255).
- R5: One clock edge after `enable` is sampled low, `sclk` equals `cpol` and no strobe is produced.
- R6: Each strobe is high for exactly one cycle. With half period H, the first `lead_pulse` appears H cycles after `enable` is first sampled high. After that the strobes alternate, leading then trailing, every H cycles, and each strobe is high in the first cycle of the new `sclk` level.
- R7: A change to `rate_cfg` while `enable` is high has no effect on the running clock. It takes effect after `enable` has been low for at least one clock edge.
- R8: `cpol`=1 inverts `sclk` and leaves the strobe timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Transfer active; the serial clock runs only while this is high |
| cpol | input | 1 | Idle level of the serial clock |
| rate_cfg | input | 13 | Bit 12 selects the law; bits 11:8 hold the exponent; bits 7:0 hold the linear field |
| sclk | output | 1 | Serial clock |
| lead_pulse | output | 1 | One-cycle strobe at each leading edge |
| trail_pulse | output | 1 | One-cycle strobe at each trailing edge |

## Verification
The hardest case to reach is a rate change that arrives in the middle of a running transfer. It must be held off until the next idle gap, while the old rate keeps producing correct edges. The stimulus starts a transfer at a short half period and rewrites the rate word a few cycles in, then watches a full serial period at the old spacing. It then drops `enable` for one cycle and checks that the next transfer runs at the new spacing. Random rate words, over both laws and both polarities, are mixed with the end values of each field.

// File: rtl/spi_div_pkg.sv
// Package: field layout of the rate word, the counter width that follows
// from it, and the decode from rate word to half period in module clocks.
package spi_div_pkg;
    localparam int EXP_W   = 4;
    localparam int LIN_W   = 8;
    localparam int SEL_BIT = EXP_W + LIN_W;
    localparam int CFG_W   = SEL_BIT + 1;
    localparam int EXP_MAX_SHIFT = (2 ** EXP_W) - 2;
    localparam int HALF_W  = ((EXP_MAX_SHIFT > LIN_W) ? EXP_MAX_SHIFT : LIN_W) + 1;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [CFG_W-1:0]  cfg_t;

    // Half period of the serial clock in module-clock cycles; never zero.
    function automatic half_t half_from_cfg(cfg_t c);
        logic [EXP_W-1:0] e;
        if (c[SEL_BIT]) begin
            return half_t'(c[LIN_W-1:0]) + half_t'(1);
        end
        e = c[SEL_BIT-1:LIN_W];
        if (e == '0) e = EXP_W'(1);
        return half_t'(1) << (e - EXP_W'(1));
    endfunction
endpackage

// File: rtl/spi_div_rate_latch.sv
// Rate latch: captures the decoded half period while the transfer is idle
// and holds it for as long as the transfer runs.
// Assumes: rate_cfg is settled for at least one edge before enable rises.
module spi_div_rate_latch
    import spi_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  cfg_t  rate_cfg,
    output half_t half
);
    // Follow the rate word while idle and freeze it during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)       half <= half_t'(1);
        else if (!enable) half <= half_from_cfg(rate_cfg);
    end

    AST_HALF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $past(rst_n)) |-> $stable(half)); // R7
    AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        half != '0); // R4
endmodule

// File: rtl/spi_div_edge_gen.sv
// Edge generator: counts module clocks up to the half period, flips the
// clock phase and raises a one-cycle strobe that names the edge just made.
// Assumes: half is nonzero and held constant while enable is high.
module spi_div_edge_gen
    import spi_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  half_t half,
    output logic  phase,
    output logic  lead,
    output logic  trail
);
    half_t cnt;
    logic  wrap;
    logic  lead_seen;

    assign wrap = (cnt == half - half_t'(1));

    // Half-period counter and phase; both return to rest when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + half_t'(1);
        end
    end

    // Edge strobes, registered alongside the phase flip.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            lead  <= 1'b0;
            trail <= 1'b0;
        end else begin
            lead  <= wrap && !phase;
            trail <= wrap &&  phase;
        end
    end

    // Checker state: a leading strobe was seen in the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) lead_seen <= 1'b0;
        else if (lead)         lead_seen <= 1'b1;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail)); // R6
    AST_LEAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> !lead); // R6
    AST_TRAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> !trail); // R6
    AST_LEAD_BEFORE_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        trail |-> lead_seen); // R6
endmodule

// File: rtl/spi_dual_div.sv
// Top: dual-law serial clock divider. Joins the rate latch to the edge
// generator and applies the polarity to the clock phase.
// Assumes: cpol changes only while enable is low.
module spi_dual_div
    import spi_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cpol,
    input  logic [CFG_W-1:0] rate_cfg,
    output logic             sclk,
    output logic             lead_pulse,
    output logic             trail_pulse
);
    half_t half;
    logic  phase;

    spi_div_rate_latch u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .rate_cfg (rate_cfg),
        .half     (half)
    );

    spi_div_edge_gen u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .half   (half),
        .phase  (phase),
        .lead   (lead_pulse),
        .trail  (trail_pulse)
    );

    // The polarity input sets the rest level of the serial clock.
    assign sclk = phase ^ cpol;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!enable) && $past(rst_n)) |-> (sclk == cpol && !lead_pulse && !trail_pulse)); // R5
    AST_TOGGLE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && $past(rst_n) && $stable(cpol) && !$stable(sclk))
            |-> (lead_pulse || trail_pulse)); // R6
endmodule

// File: tb/spi_dual_div_tb.sv
module spi_dual_div_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cpol = 1'b0;
    logic [12:0] rate_cfg = '0;
    logic        sclk, lead_pulse, trail_pulse;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_dual_div u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol),
        .rate_cfg(rate_cfg), .sclk(sclk),
        .lead_pulse(lead_pulse), .trail_pulse(trail_pulse)
    );

    // Half period from the requirements (R2, R3, R4).
    function automatic int exp_half(logic [12:0] c);
        int e;
        if (c[12]) return int'(c[7:0]) + 1;
        e = int'(c[11:8]);
        if (e == 0) e = 1;
        return 1 << (e - 1);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_check(string req);
        @(negedge clk);
        check(sclk == cpol && !lead_pulse && !trail_pulse, req, "idle level/strobes",
              {sclk, lead_pulse, trail_pulse}, {cpol, 2'b00});
    endtask

    // Runs one transfer of two full serial periods and checks every cycle.
    task automatic run_window(int h, string req, bit do_change, logic [12:0] new_cfg);
        int pulse_err = 0, lvl_err = 0, first_i = -1, act = 0, exp = 0;
        enable = 1'b1;
        for (int i = 1; i <= 4 * h; i++) begin
            bit el, et, ep;
            @(negedge clk);
            if (do_change && i == 2) rate_cfg = new_cfg;
            el = (i == h) || (i == 3 * h);
            et = (i == 2 * h) || (i == 4 * h);
            ep = ((i / h) % 2) == 1;
            if (lead_pulse != el || trail_pulse != et) begin
                if (pulse_err == 0) begin
                    first_i = i; act = {lead_pulse, trail_pulse}; exp = {el, et};
                end
                pulse_err++;
            end
            if (sclk != (ep ^ cpol)) lvl_err++;
        end
        check(pulse_err == 0, req, $sformatf("strobe timing h=%0d first bad cycle %0d", h, first_i), act, exp);
        check(lvl_err == 0, req, $sformatf("sclk level h=%0d mismatches", h), lvl_err, 0);
        enable = 1'b0;
        idle_check("R5");
    endtask

    task automatic run_cfg(logic [12:0] c, logic pol, string req);
        rate_cfg = c;
        cpol = pol;
        @(negedge clk);
        @(negedge clk);
        run_window(exp_half(c), req, 1'b0, '0);
    endtask

    initial begin
        int seed;
        seed = 12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check(sclk == cpol && !lead_pulse && !trail_pulse, "R1", "reset outputs",
              {sclk, lead_pulse, trail_pulse}, 0);
        rst_n = 1'b1;
        idle_check("R1");

        // Directed corners of both laws.
        run_cfg(13'h0000, 1'b0, "R3");           // e=0 -> divide by 2
        run_cfg(13'h0100, 1'b0, "R2");           // e=1
        run_cfg(13'h0500, 1'b0, "R2");           // e=5, h=16
        run_cfg(13'h0D00, 1'b0, "R2");           // e=13, h=4096
        run_cfg(13'h1000, 1'b0, "R4");           // f=0, ratio 2
        run_cfg(13'h10FF, 1'b0, "R4");           // f=255, ratio 512
        run_cfg(13'h1002, 1'b1, "R8");           // inverted polarity
        run_cfg(13'h0300, 1'b1, "R8");

        // Holding enable low keeps the clock at rest.
        rate_cfg = 13'h1000;
        repeat (5) idle_check("R5");

        // Rate change in mid transfer: old spacing kept, new one after idle.
        cpol = 1'b0;
        rate_cfg = 13'h1001;                     // h=2
        @(negedge clk);
        run_window(2, "R7", 1'b1, 13'h1007);     // change to h=8 during run
        run_window(8, "R7", 1'b0, '0);

        // Random rate words over both laws and polarities.
        for (int k = 0; k < 12; k++) begin
            logic [12:0] c;
            c = 13'($urandom);
            if (c[12]) c[7:0] = {2'b00, c[5:0]};
            else       c[11:8] = {1'b0, c[10:8]};
            run_cfg(c, 1'($urandom), c[12] ? "R4" : "R2");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule